// File: doc/BRIEF.md
# Load/Store Queue Occupancy Controller

This block tracks the occupancy of two circular queues, one for loads and one for stores, that a dispatch stage fills through a shared allocation interface. Each allocated entry carries a sequence number. The block holds only bookkeeping state: valid bits, sequence numbers and store lifecycle flags. It carries no data, addresses or forwarding. Dispatch uses the full flags and the free-entry count to decide whether it may issue further memory operations.

A load entry lives from allocation until it commits at the load head. A store entry has a longer life. A commit marks it eligible for writeback. A write is then issued from a separate writeback pointer when the cache is not blocked. The entry is released from the store head only after the memory system reports that the write has completed. A squash drops every entry younger than a given sequence number from both queues. Each tail pointer then returns to the position just past the youngest survivor.

Top module: `lsq_occupancy_ctrl`

## Requirements
- R1: The load count reaches at most LQ_DEPTH-1, and `ld_full_o` is 1 exactly when it equals LQ_DEPTH-1. A load allocation while the queue is full is dropped and leaves the count unchanged.
- R2: The store count reaches at most SQ_DEPTH-1, and `st_full_o` is 1 exactly when it equals SQ_DEPTH-1. A store allocation while the queue is full is dropped.
- R3: `full_o` is the OR of the two full flags. `free_cnt_o` is the smaller of (LQ_DEPTH-1 minus load count) and (SQ_DEPTH-1 minus store count).
- R4: `ld_commit_i` releases the oldest load at the next edge. With an empty load queue it has no effect.
- R5: `st_commit_i` marks as eligible every valid store whose sequence number is strictly below `st_commit_seq_i`. `st_wb_pend_o` counts the stores that are eligible but not yet issued.
- R6: `wb_fire_o` is 1 in the same cycle in which the store at `wb_idx_o` is eligible, not completed, and `cache_blocked_i` is 0. After each issue, `wb_idx_o` advances by one and `st_wb_pend_o` drops by one.
- R7: A store stays counted in `st_cnt_o` after it commits and after it issues. `wb_cpl_i` together with `wb_cpl_idx_i` marks the store at that index as completed. The store at the head is released at the next edge once it is completed, one store per cycle, so a younger store that completes first waits behind the head.
- R8: `squash_i` removes every entry whose sequence number is greater than `squash_seq_i` from both queues at the next edge. Allocation requests in a squash cycle are ignored.
- R9: All pointers wrap modulo their queue depth, including for depths that are not a power of two. `wb_idx_o` gives the store slot index, 0 to SQ_DEPTH-1.
- R10: After reset both counts and `st_wb_pend_o` are 0, `wb_idx_o` is 0, `wb_fire_o` is 0, and `free_cnt_o` is min(LQ_DEPTH-1, SQ_DEPTH-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_alloc_i | input | 1 | Allocate a load entry |
| ld_seq_i | input | SEQ_W | Sequence number of the new load |
| st_alloc_i | input | 1 | Allocate a store entry |
| st_seq_i | input | SEQ_W | Sequence number of the new store |
| ld_commit_i | input | 1 | Commit and release the head load |
| st_commit_i | input | 1 | Mark older stores eligible for writeback |
| st_commit_seq_i | input | SEQ_W | Stores with sequence number below this become eligible |
| cache_blocked_i | input | 1 | Cache cannot accept a write this cycle |
| wb_cpl_i | input | 1 | A store write has completed |
| wb_cpl_idx_i | input | $clog2(SQ_DEPTH) | Slot index of the completed store |
| squash_i | input | 1 | Squash younger entries |
| squash_seq_i | input | SEQ_W | Youngest sequence number that survives |
| ld_full_o | output | 1 | Load queue full |
| st_full_o | output | 1 | Store queue full |
| full_o | output | 1 | Either queue full |
| free_cnt_o | output | max of count widths | Free entries usable by both queues |
| ld_cnt_o | output | $clog2(LQ_DEPTH+1) | Loads held |
| st_cnt_o | output | $clog2(SQ_DEPTH+1) | Stores held |
| st_wb_pend_o | output | $clog2(SQ_DEPTH+1) | Eligible stores not yet issued |
| wb_fire_o | output | 1 | Issue a store write this cycle |
| wb_idx_o | output | $clog2(SQ_DEPTH) | Slot at the writeback pointer |

## Verification
A pointer that drifts from its count, or a lost lifecycle flag, shows up at the ports within a few cycles. A stuck entry keeps `st_cnt_o` high and lowers `free_cnt_o`. A misplaced writeback pointer gives a wrong `wb_idx_o`, or gives `wb_fire_o` for a store that is not eligible, in the very cycle it is consulted. A wrong squash survivor count moves the tail, and the next allocations and counts diverge at once. The bench compares every output against a behavioural model on every cycle, so each such fault is reported in the first cycle where it becomes visible.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  // modular ring advance; depth need not be a power of two
  function automatic int ring_add(int ptr, int step, int depth);
    return (ptr + step) % depth;
  endfunction
endpackage

// File: rtl/lq_ctrl.sv
module lq_ctrl #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [SEQ_W-1:0] alloc_seq_i,
  input  logic             commit_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic [CW-1:0]    cnt_o,
  output logic             full_o
);
  import lsq_pkg::*;

  logic [DEPTH-1:0] vld_q, vld_n, kill;
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PW-1:0]    head_q, tail_q, head_n, tail_n;
  logic [CW-1:0]    cnt_q, cnt_n, surv;
  logic             alloc_ok, pop;

  assign full_o   = (cnt_q == CW'(DEPTH - 1));
  assign alloc_ok = alloc_i & ~squash_i & ~full_o;
  assign pop      = commit_i & (cnt_q != '0);
  assign cnt_o    = cnt_q;

  always_comb begin
    surv = '0;
    for (int i = 0; i < DEPTH; i++) begin
      kill[i] = vld_q[i] & (seq_q[i] > squash_seq_i);
      if (vld_q[i] && !kill[i]) surv = surv + CW'(1);
    end
  end

  always_comb begin
    vld_n  = vld_q;
    tail_n = tail_q;
    head_n = head_q;
    cnt_n  = cnt_q;
    if (squash_i) begin
      vld_n  = vld_q & ~kill;
      tail_n = PW'(ring_add(int'(head_q), int'(surv), DEPTH));
      cnt_n  = surv - CW'(pop);
    end else begin
      if (alloc_ok) begin
        vld_n[tail_q] = 1'b1;
        tail_n = PW'(ring_add(int'(tail_q), 1, DEPTH));
      end
      cnt_n = cnt_q + CW'(alloc_ok) - CW'(pop);
    end
    if (pop) begin
      vld_n[head_q] = 1'b0;
      head_n = PW'(ring_add(int'(head_q), 1, DEPTH));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q  <= vld_n;
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_ok) seq_q[tail_q] <= alloc_seq_i;
  end

  p_cnt_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH - 1));
  p_full_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && alloc_i && !commit_i && !squash_i) |=> cnt_q == $past(cnt_q));
  p_ring_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) == ring_add(int'(tail_q), DEPTH - int'(head_q), DEPTH));
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl #(
  parameter int DEPTH = 6,
  parameter int SEQ_W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [SEQ_W-1:0] alloc_seq_i,
  input  logic             commit_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  input  logic             blocked_i,
  input  logic             cpl_i,
  input  logic [PW-1:0]    cpl_idx_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic [CW-1:0]    cnt_o,
  output logic             full_o,
  output logic [CW-1:0]    pend_o,
  output logic             fire_o,
  output logic [PW-1:0]    wb_idx_o
);
  import lsq_pkg::*;

  logic [DEPTH-1:0] vld_q, elig_q, done_q, vld_n, elig_n, done_n, kill, newly;
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PW-1:0]    head_q, wbp_q, tail_q, head_n, wbp_n, tail_n;
  logic [CW-1:0]    cnt_q, pend_q, cnt_n, pend_n, surv, n_new;
  logic             alloc_ok, release_hd, cpl_ok;

  assign full_o     = (cnt_q == CW'(DEPTH - 1));
  assign alloc_ok   = alloc_i & ~squash_i & ~full_o;
  assign fire_o     = vld_q[wbp_q] & elig_q[wbp_q] & ~done_q[wbp_q] & ~blocked_i;
  assign release_hd = vld_q[head_q] & done_q[head_q];
  assign cpl_ok     = cpl_i && (int'(cpl_idx_i) < DEPTH) && vld_q[cpl_idx_i] && elig_q[cpl_idx_i];
  assign cnt_o      = cnt_q;
  assign pend_o     = pend_q;
  assign wb_idx_o   = wbp_q;

  always_comb begin
    surv  = '0;
    n_new = '0;
    for (int i = 0; i < DEPTH; i++) begin
      kill[i]  = vld_q[i] & (seq_q[i] > squash_seq_i);
      newly[i] = commit_i & vld_q[i] & ~elig_q[i] & (seq_q[i] < commit_seq_i);
      if (vld_q[i] && !kill[i]) surv = surv + CW'(1);
      if (newly[i]) n_new = n_new + CW'(1);
    end
  end

  always_comb begin
    vld_n  = vld_q;
    elig_n = elig_q | newly;
    done_n = done_q;
    tail_n = tail_q;
    head_n = head_q;
    wbp_n  = wbp_q;
    if (cpl_ok) done_n[cpl_idx_i] = 1'b1;
    if (squash_i) begin
      vld_n  = vld_q & ~kill;
      tail_n = PW'(ring_add(int'(head_q), int'(surv), DEPTH));
      cnt_n  = surv - CW'(release_hd);
    end else begin
      if (alloc_ok) begin
        vld_n[tail_q]  = 1'b1;
        elig_n[tail_q] = 1'b0;
        done_n[tail_q] = 1'b0;
        tail_n = PW'(ring_add(int'(tail_q), 1, DEPTH));
      end
      cnt_n = cnt_q + CW'(alloc_ok) - CW'(release_hd);
    end
    if (release_hd) begin
      vld_n[head_q] = 1'b0;
      head_n = PW'(ring_add(int'(head_q), 1, DEPTH));
    end
    if (fire_o) wbp_n = PW'(ring_add(int'(wbp_q), 1, DEPTH));
    pend_n = pend_q + n_new - CW'(fire_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      elig_q <= '0;
      done_q <= '0;
      head_q <= '0;
      wbp_q  <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      vld_q  <= vld_n;
      elig_q <= elig_n;
      done_q <= done_n;
      head_q <= head_n;
      wbp_q  <= wbp_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_ok) seq_q[tail_q] <= alloc_seq_i;
  end

  p_cnt_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH - 1));
  p_pend_le_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= cnt_q);
  p_wb_adv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> wbp_q != $past(wbp_q));
  p_hold_head_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q[head_q] && !done_q[head_q] && !squash_i) |=> cnt_q >= $past(cnt_q));
  p_squash_shrink_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/lsq_occupancy_ctrl.sv
module lsq_occupancy_ctrl #(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 6,
  parameter int SEQ_W    = 16,
  localparam int LCW = $clog2(LQ_DEPTH + 1),
  localparam int SCW = $clog2(SQ_DEPTH + 1),
  localparam int SPW = $clog2(SQ_DEPTH),
  localparam int FW  = (LCW > SCW) ? LCW : SCW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_alloc_i,
  input  logic [SEQ_W-1:0] ld_seq_i,
  input  logic             st_alloc_i,
  input  logic [SEQ_W-1:0] st_seq_i,
  input  logic             ld_commit_i,
  input  logic             st_commit_i,
  input  logic [SEQ_W-1:0] st_commit_seq_i,
  input  logic             cache_blocked_i,
  input  logic             wb_cpl_i,
  input  logic [SPW-1:0]   wb_cpl_idx_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic             ld_full_o,
  output logic             st_full_o,
  output logic             full_o,
  output logic [FW-1:0]    free_cnt_o,
  output logic [LCW-1:0]   ld_cnt_o,
  output logic [SCW-1:0]   st_cnt_o,
  output logic [SCW-1:0]   st_wb_pend_o,
  output logic             wb_fire_o,
  output logic [SPW-1:0]   wb_idx_o
);
  logic [FW-1:0] ld_free, st_free;

  lq_ctrl #(.DEPTH(LQ_DEPTH), .SEQ_W(SEQ_W)) u_lq (
    .clk_i, .rst_ni,
    .alloc_i      (ld_alloc_i),
    .alloc_seq_i  (ld_seq_i),
    .commit_i     (ld_commit_i),
    .squash_i     (squash_i),
    .squash_seq_i (squash_seq_i),
    .cnt_o        (ld_cnt_o),
    .full_o       (ld_full_o)
  );

  sq_ctrl #(.DEPTH(SQ_DEPTH), .SEQ_W(SEQ_W)) u_sq (
    .clk_i, .rst_ni,
    .alloc_i      (st_alloc_i),
    .alloc_seq_i  (st_seq_i),
    .commit_i     (st_commit_i),
    .commit_seq_i (st_commit_seq_i),
    .blocked_i    (cache_blocked_i),
    .cpl_i        (wb_cpl_i),
    .cpl_idx_i    (wb_cpl_idx_i),
    .squash_i     (squash_i),
    .squash_seq_i (squash_seq_i),
    .cnt_o        (st_cnt_o),
    .full_o       (st_full_o),
    .pend_o       (st_wb_pend_o),
    .fire_o       (wb_fire_o),
    .wb_idx_o     (wb_idx_o)
  );

  assign ld_free    = FW'(LQ_DEPTH - 1) - FW'(ld_cnt_o);
  assign st_free    = FW'(SQ_DEPTH - 1) - FW'(st_cnt_o);
  assign free_cnt_o = (ld_free < st_free) ? ld_free : st_free;
  assign full_o     = ld_full_o | st_full_o;

  p_full_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> free_cnt_o == '0);
endmodule

// File: tb/lsq_occupancy_ctrl_bench.sv
module lsq_occupancy_ctrl_bench;
  localparam int LQ = 8;
  localparam int SQ = 6;
  localparam int SW = 16;
  localparam int LCW = $clog2(LQ + 1);
  localparam int SCW = $clog2(SQ + 1);
  localparam int SPW = $clog2(SQ);
  localparam int FW  = (LCW > SCW) ? LCW : SCW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_alloc = 0, st_alloc = 0, ld_commit = 0, st_commit = 0, blk = 0, cpl = 0, squash = 0;
  logic [SW-1:0] ld_seq = '0, st_seq = '0, cseq = '0, sqseq = '0;
  logic [SPW-1:0] cpl_idx = '0;
  logic ld_full, st_full, full, fire;
  logic [FW-1:0] free_cnt;
  logic [LCW-1:0] ld_cnt;
  logic [SCW-1:0] st_cnt, pend;
  logic [SPW-1:0] wb_idx;

  always #5 clk = ~clk;

  lsq_occupancy_ctrl u_lsq_occupancy_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_alloc_i(ld_alloc), .ld_seq_i(ld_seq), .st_alloc_i(st_alloc), .st_seq_i(st_seq),
    .ld_commit_i(ld_commit), .st_commit_i(st_commit), .st_commit_seq_i(cseq),
    .cache_blocked_i(blk), .wb_cpl_i(cpl), .wb_cpl_idx_i(cpl_idx),
    .squash_i(squash), .squash_seq_i(sqseq),
    .ld_full_o(ld_full), .st_full_o(st_full), .full_o(full), .free_cnt_o(free_cnt),
    .ld_cnt_o(ld_cnt), .st_cnt_o(st_cnt), .st_wb_pend_o(pend),
    .wb_fire_o(fire), .wb_idx_o(wb_idx)
  );

  typedef struct { int seq; bit elig; bit iss; bit done; } st_ent_t;
  int lq_m[$];
  st_ent_t sq_m[$];
  int shead = 0, m_pend = 0, fk = 0, nseq = 1;
  bit m_fire, was_squash, finished = 0;
  int total = 0, fails = 0;
  int unsigned lfsr = 32'h1234_5678;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned rnd();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  task automatic compare();
    int ldc = lq_m.size(), stc = sq_m.size(), lf = LQ - 1 - ldc, sf = SQ - 1 - stc;
    fk = stc;
    for (int k = 0; k < stc; k++) if (!sq_m[k].iss) begin fk = k; break; end
    m_fire = (fk < stc) && sq_m[fk].elig && !blk;
    chk("R4 ld_cnt", int'(ld_cnt), ldc);
    chk("R1 ld_full", int'(ld_full), int'(ldc == LQ - 1));
    chk("R2 st_full", int'(st_full), int'(stc == SQ - 1));
    chk("R3 full", int'(full), int'(ldc == LQ - 1 || stc == SQ - 1));
    chk("R3 free_cnt", int'(free_cnt), (lf < sf) ? lf : sf);
    chk("R7 st_cnt", int'(st_cnt), stc);
    chk("R5 pend", int'(pend), m_pend);
    chk("R6 fire", int'(fire), int'(m_fire));
    chk("R9 wb_idx", int'(wb_idx), (shead + fk) % SQ);
    if (was_squash) begin
      chk("R8 ld_cnt after squash", int'(ld_cnt), ldc);
      chk("R8 st_cnt after squash", int'(st_cnt), stc);
    end
  endtask

  task automatic model_update();
    bit rel = (sq_m.size() > 0) && sq_m[0].done;
    if (squash) begin
      while (lq_m.size() > 0 && lq_m[$] > int'(sqseq)) void'(lq_m.pop_back());
    end else if (ld_alloc && lq_m.size() < LQ - 1) lq_m.push_back(int'(ld_seq));
    if (ld_commit && lq_m.size() > 0) void'(lq_m.pop_front());
    if (st_commit)
      for (int k = 0; k < sq_m.size(); k++)
        if (!sq_m[k].elig && sq_m[k].seq < int'(cseq)) begin sq_m[k].elig = 1; m_pend++; end
    if (cpl) begin
      int k = (int'(cpl_idx) - shead + SQ) % SQ;
      if (k < sq_m.size() && sq_m[k].iss) sq_m[k].done = 1;
    end
    if (m_fire) begin sq_m[fk].iss = 1; m_pend--; end
    if (squash) begin
      while (sq_m.size() > 0 && sq_m[$].seq > int'(sqseq)) void'(sq_m.pop_back());
    end else if (st_alloc && sq_m.size() < SQ - 1) begin
      st_ent_t e; e.seq = int'(st_seq); e.elig = 0; e.iss = 0; e.done = 0;
      sq_m.push_back(e);
    end
    if (rel) begin void'(sq_m.pop_front()); shead = (shead + 1) % SQ; end
  endtask

  task automatic clear_in();
    ld_alloc = 0; st_alloc = 0; ld_commit = 0; st_commit = 0;
    blk = 0; cpl = 0; squash = 0;
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_update();
    was_squash = squash;
    @(negedge clk);
    clear_in();
  endtask

  task automatic alloc_both();
    ld_alloc = 1; st_alloc = 1;
    ld_seq = SW'(nseq); st_seq = SW'(nseq + 1); nseq += 2;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state
    chk("R10 ld_cnt", int'(ld_cnt), 0);
    chk("R10 st_cnt", int'(st_cnt), 0);
    chk("R10 pend", int'(pend), 0);
    chk("R10 wb_idx", int'(wb_idx), 0);
    chk("R10 fire", int'(fire), 0);
    chk("R10 free", int'(free_cnt), SQ - 1);
    @(negedge clk);
    // fill past full on both queues (R1, R2)
    for (int i = 0; i < 9; i++) begin alloc_both(); tick(); end
    // commit stores seq 2,4,6 while cache blocked (R5, R6)
    st_commit = 1; cseq = 7; blk = 1; tick();
    blk = 1; tick();
    for (int i = 0; i < 3; i++) tick();
    // out-of-order completion: slot 1 first, head must wait (R7)
    cpl = 1; cpl_idx = 1; tick();
    tick();
    cpl = 1; cpl_idx = 0; tick();
    tick(); tick();
    // squash with allocation requested in the same cycle (R8)
    squash = 1; sqseq = 7; alloc_both(); tick();
    tick();
    // long mixed traffic for wrap-around (R9)
    for (int c = 0; c < 3000; c++) begin
      int unsigned r = rnd();
      if (r[3:0] == 4'd0) begin
        int flo = 0, cand = nseq - 2 - 2 * int'(r[5:4]);
        foreach (sq_m[k]) if (sq_m[k].elig && sq_m[k].seq > flo) flo = sq_m[k].seq;
        if (cand < flo) cand = flo;
        squash = 1; sqseq = SW'(cand);
        if (r[6]) alloc_both();
      end else begin
        if (r[7]) begin ld_alloc = 1; ld_seq = SW'(nseq); end
        if (r[8]) begin st_alloc = 1; st_seq = SW'(nseq + 1); end
        nseq += 2;
        ld_commit = r[9] && (lq_m.size() > 0);
        if (r[10]) begin
          for (int k = 0; k < sq_m.size(); k++)
            if (!sq_m[k].elig) begin
              int kk = (r[11] && k + 1 < sq_m.size()) ? k + 1 : k;
              st_commit = 1; cseq = SW'(sq_m[kk].seq + 1);
              break;
            end
        end
      end
      blk = r[12] & r[13];
      if (r[14]) begin
        int first = -1, second = -1;
        foreach (sq_m[k]) if (sq_m[k].iss && !sq_m[k].done) begin
          if (first < 0) first = k; else if (second < 0) second = k;
        end
        if (first >= 0) begin
          cpl = 1;
          cpl_idx = SPW'((shead + ((r[15] && second >= 0) ? second : first)) % SQ);
        end
      end
      tick();
    end
    summary();
  end
endmodule